// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block sits between a small 8-bit processor core and off-chip program and data memory. The core presents one request at a time: an instruction fetch, a data read or a data write, with a 16-bit byte address into a 64K-byte space. The block then runs a bus cycle and signals completion with a one-cycle `done` pulse. For reads and fetches, the returned byte appears on `rdata` during that pulse. The core holds off further requests until it sees `done`.

The low address byte and all data travel on one shared 8-bit port. That port is modelled as separate output, output-enable and input vectors, and the pad ring builds the bidirectional pin from them. The high address byte has a dedicated 8-bit port. An address-latch strobe lets external logic capture the low address. Active-low read and write strobes then frame the data phase.

All timing runs from a clock at twice the core rate, so half-core-clock phases are exact. One half-clock is called a "half" below. A strap input `int_prog_en` decides where fetches go. When it is high, fetches in 0000H..3FFFH are served by an internal stub that stands in for on-chip program memory. When it is low, every fetch goes to the external bus.

Top module: `membus_if`

## Requirements
- R1: During and immediately after synchronous reset: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0.
- R2: An external access accepted at a clock edge has two address phases:
  - `ale` is high for exactly the first three halves after that edge (halves 1..3).
  - In halves 1..4, `ad_oe`=1 and `ad_out` carries address bits 7:0, so the low address is held one half after `ale` falls.
- R3: For an external read (kind 1, or kind 3 which is treated as a read):
  - `rd_n` is low in halves 5..7 and `ad_oe` is 0 from half 5.
  - The value on `ad_in` at the edge that ends half 7 (when `rd_n` rises) is returned on `rdata` in half 8.
- R4: For a write (kind 2):
  - `wr_n` is low in halves 5..7.
  - `ad_out` carries the write byte with `ad_oe`=1 in halves 5..8, which is one half past the rising edge of `wr_n`.
- R5: `a_hi` carries address bits 15:8 and stays constant through halves 1..7 of an external access.
- R6: A fetch (kind 0) with `int_prog_en`=1 and address ≤ 3FFFH produces no strobe and no drive on the shared port. `done` rises in half 1, with `rdata` = addr[7:0] XOR addr[15:8] XOR 5AH.
- R7: A fetch with `int_prog_en`=0 at any address, or with address ≥ 4000H, runs an external read cycle as in R3.
- R8: Data reads and writes always use the external bus, whatever the value of `int_prog_en`.
- R9: `done` is a single-half pulse:
  - It is asserted in half 8 of an external access or in half 1 of an internal fetch.
  - Each accepted request produces exactly one pulse.
  - A `req_valid` raised while an access is in progress is ignored and starts no bus cycle.
- R10: Between accesses, `rd_n`=`wr_n`=1, `ale`=0 and `ad_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the core clock rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| int_prog_en | input | 1 | Strap: 1 serves fetches below 4000H internally |
| done | output | 1 | One-half completion pulse |
| rdata | output | 8 | Returned byte, valid with `done` |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |
| a_hi | output | 8 | High address byte |

## Verification
Every pin is registered from the next-state decode, so each pin changes at the first edge after acceptance and then stays put for a whole number of halves. The bench raises a request at a falling edge and lets it be taken at the next rising edge. It then samples at each following falling edge, so the Nth sample falls in half N. External accesses are checked pin by pin over halves 1..9. Internal fetches are checked over halves 1..2.

Read data is placed on `ad_in` in half 5 and must appear on `rdata` in half 8, the same half as `done`. A request injected in half 3 is followed by three further idle halves, which must show no `ale` and no `done`.

// File: rtl/membus_pkg.sv
package membus_pkg;

    localparam int ADDR_W        = 16;
    localparam int DATA_W        = 8;
    localparam int HI_W          = ADDR_W - DATA_W;
    localparam int LATCH_HALVES  = 4;
    localparam int STROBE_HALVES = 3;
    localparam int MAX_HALVES    = (LATCH_HALVES > STROBE_HALVES) ? LATCH_HALVES : STROBE_HALVES;
    localparam int CNT_W         = $clog2(MAX_HALVES);

    localparam logic [ADDR_W-1:0] INT_PROG_LAST = 16'h3FFF;
    localparam logic [DATA_W-1:0] STUB_SALT     = 8'h5A;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_READ2 = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LATCH  = 2'd1,
        ST_STROBE = 2'd2,
        ST_DONE   = 2'd3
    } seq_e;

    typedef struct packed {
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic              ale;
        logic              rd_n;
        logic              wr_n;
        logic              ad_oe;
        logic [DATA_W-1:0] ad_out;
        logic [HI_W-1:0]   a_hi;
    } pins_t;

    localparam pins_t PINS_RESET = '{ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1, ad_oe: 1'b0,
                                     ad_out: '0, a_hi: '0};

    function automatic logic is_write(kind_e k);
        return k == K_WRITE;
    endfunction

    function automatic logic [DATA_W-1:0] rom_stub(logic [ADDR_W-1:0] a);
        return a[DATA_W-1:0] ^ a[ADDR_W-1:DATA_W] ^ STUB_SALT;
    endfunction

    // Pin levels for a given sequencer position; registered by the caller.
    function automatic pins_t pins_for(seq_e st, logic [CNT_W-1:0] cnt, req_t r, logic ext);
        pins_t p;
        logic  wr;
        wr       = is_write(r.kind);
        p        = PINS_RESET;
        p.a_hi   = r.addr[ADDR_W-1:DATA_W];
        case (st)
            ST_LATCH: begin
                p.ale    = (cnt < CNT_W'(LATCH_HALVES - 1));
                p.ad_oe  = 1'b1;
                p.ad_out = r.addr[DATA_W-1:0];
            end
            ST_STROBE: begin
                p.rd_n   = wr;
                p.wr_n   = !wr;
                p.ad_oe  = wr;
                p.ad_out = wr ? r.wdata : '0;
            end
            ST_DONE: begin
                p.ad_oe  = wr && ext;
                p.ad_out = (wr && ext) ? r.wdata : '0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/membus_route.sv
module membus_route
    import membus_pkg::*;
(
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              int_prog_en,
    output logic              go_ext,
    output logic [DATA_W-1:0] stub_data
);

    logic in_int_window;

    always_comb begin
        in_int_window = (addr <= INT_PROG_LAST);
        go_ext        = !((kind == K_FETCH) && int_prog_en && in_int_window);
        stub_data     = rom_stub(addr);
    end

endmodule

// File: rtl/membus_seq.sv
module membus_seq
    import membus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             go_ext,
    output seq_e             st,
    output logic [CNT_W-1:0] cnt,
    output seq_e             st_d,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] LATCH_LAST  = CNT_W'(LATCH_HALVES - 1);
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_HALVES - 1);

    always_comb begin
        st_d  = st;
        cnt_d = cnt;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    st_d  = go_ext ? ST_LATCH : ST_DONE;
                    cnt_d = '0;
                end
            end
            ST_LATCH: begin
                if (cnt == LATCH_LAST) begin
                    st_d  = ST_STROBE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt == STROBE_LAST) begin
                    st_d  = ST_DONE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_d;
            cnt <= cnt_d;
        end
    end

endmodule

// File: rtl/membus_pins.sv
module membus_pins
    import membus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_e              st_d,
    input  logic [CNT_W-1:0]  cnt_d,
    input  req_t              req_d,
    input  logic              ext_d,
    input  seq_e              st,
    input  logic [CNT_W-1:0]  cnt,
    input  req_t              req_q,
    input  logic              start,
    input  logic              go_ext,
    input  logic [DATA_W-1:0] stub_data,
    input  logic [DATA_W-1:0] ad_in,
    output pins_t             pins_q,
    output logic              done_q,
    output logic [DATA_W-1:0] rdata_q
);

    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_HALVES - 1);

    logic capture_ext;
    logic capture_int;

    always_comb begin
        capture_ext = (st == ST_STROBE) && (cnt == STROBE_LAST) && !is_write(req_q.kind);
        capture_int = start && !go_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q  <= PINS_RESET;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            pins_q <= pins_for(st_d, cnt_d, req_d, ext_d);
            done_q <= (st_d == ST_DONE);
            if (capture_int) begin
                rdata_q <= stub_data;
            end else if (capture_ext) begin
                rdata_q <= ad_in;
            end
        end
    end

endmodule

// File: rtl/membus_if.sv
module membus_if
    import membus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              int_prog_en,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   a_hi
);

    kind_e             kind_in;
    req_t              req_q;
    req_t              req_d;
    logic              ext_q;
    logic              ext_d;
    seq_e              st;
    seq_e              st_d;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_d;
    logic              start;
    logic              go_ext;
    logic [DATA_W-1:0] stub_data;
    pins_t             pins_q;

    assign kind_in = kind_e'(req_kind);
    assign start   = req_valid && (st == ST_IDLE);

    membus_route u_route (
        .kind        (kind_in),
        .addr        (req_addr),
        .int_prog_en (int_prog_en),
        .go_ext      (go_ext),
        .stub_data   (stub_data)
    );

    membus_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .go_ext (go_ext),
        .st     (st),
        .cnt    (cnt),
        .st_d   (st_d),
        .cnt_d  (cnt_d)
    );

    always_comb begin
        req_d = req_q;
        ext_d = ext_q;
        if (start) begin
            req_d.kind  = kind_in;
            req_d.addr  = req_addr;
            req_d.wdata = req_wdata;
            ext_d       = go_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{kind: K_FETCH, addr: '0, wdata: '0};
            ext_q <= 1'b0;
        end else begin
            req_q <= req_d;
            ext_q <= ext_d;
        end
    end

    membus_pins u_pins (
        .clk       (clk),
        .rst       (rst),
        .st_d      (st_d),
        .cnt_d     (cnt_d),
        .req_d     (req_d),
        .ext_d     (ext_d),
        .st        (st),
        .cnt       (cnt),
        .req_q     (req_q),
        .start     (start),
        .go_ext    (go_ext),
        .stub_data (stub_data),
        .ad_in     (ad_in),
        .pins_q    (pins_q),
        .done_q    (done),
        .rdata_q   (rdata)
    );

    assign ale    = pins_q.ale;
    assign rd_n   = pins_q.rd_n;
    assign wr_n   = pins_q.wr_n;
    assign ad_oe  = pins_q.ad_oe;
    assign ad_out = pins_q.ad_out;
    assign a_hi   = pins_q.a_hi;

endmodule

// File: rtl/membus_chk.sv
module membus_chk
    import membus_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ad_oe,
    input logic [HI_W-1:0] a_hi,
    input logic            done
);

    AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale ##1 ale ##1 !ale);                       // R2
    AST_ALE_FALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (ad_oe && $stable(a_hi)));                   // R2
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));                                    // R2
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |=> !rd_n ##1 !rd_n ##1 rd_n);                  // R3
    AST_RD_PORT_FLOAT: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);                                          // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));                                         // R3
    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |=> !wr_n ##1 !wr_n ##1 wr_n);                  // R4
    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);                                           // R4
    AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> ad_oe);                                     // R4
    AST_AHI_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> $stable(a_hi));                        // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                            // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ale && rd_n && wr_n));                           // R10

endmodule

bind membus_if membus_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .ale   (ale),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .ad_oe (ad_oe),
    .a_hi  (a_hi),
    .done  (done)
);

// File: tb/sim_membus_if.sv
module sim_membus_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0000;
    logic [7:0]  req_wdata = 8'h00;
    logic        int_prog_en = 1'b0;
    logic        done;
    logic [7:0]  rdata;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = 8'h00;
    logic [7:0]  a_hi;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    membus_if u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .int_prog_en(int_prog_en),
        .done(done), .rdata(rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] stub_exp(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic bit goes_ext(input logic [1:0] k, input logic [15:0] a, input bit ien);
        return !(k == 2'd0 && ien && a <= 16'h3FFF);
    endfunction

    task automatic access(input logic [1:0] kind, input logic [15:0] addr,
                          input logic [7:0] wd, input bit ien, input bit poke);
        bit         ext;
        bit         wr;
        logic [7:0] mem_val;
        string      rtag;
        ext     = goes_ext(kind, addr, ien);
        wr      = (kind == 2'd2);
        mem_val = 8'($urandom);
        rtag    = (kind == 2'd0) ? "R7" : (ien ? "R8" : "R3");
        @(negedge clk);
        req_valid   = 1'b1;
        req_kind    = kind;
        req_addr    = addr;
        req_wdata   = wd;
        int_prog_en = ien;
        @(negedge clk);
        req_valid = 1'b0;
        if (!ext) begin
            chk("R6 done", 16'(done), 16'd1);
            chk("R6 rdata", 16'(rdata), 16'(stub_exp(addr)));
            chk("R6 ale", 16'(ale), 16'd0);
            chk("R6 strobes", {14'd0, rd_n, wr_n}, 16'h3);
            chk("R6 ad_oe", 16'(ad_oe), 16'd0);
            @(negedge clk);
            chk("R9 done low", 16'(done), 16'd0);
            chk("R10 idle", {12'd0, ale, rd_n, wr_n, ad_oe}, 16'b0110);
        end else begin
            for (int h = 1; h <= 9; h++) begin
                if (h > 1) @(negedge clk);
                if (h == 5) ad_in = mem_val;
                if (poke && h == 3) begin
                    req_valid = 1'b1;
                    req_addr  = 16'hBEEF;
                    req_kind  = 2'd2;
                end
                if (poke && h == 4) req_valid = 1'b0;
                chk("R2 ale", 16'(ale), 16'(h <= 3));
                chk(wr ? "R4 rd_n" : "R3 rd_n", 16'(rd_n), 16'(!(!wr && h >= 5 && h <= 7)));
                chk("R4 wr_n", 16'(wr_n), 16'(!(wr && h >= 5 && h <= 7)));
                if (h <= 4) begin
                    chk("R2 ad_oe", 16'(ad_oe), 16'd1);
                    chk("R2 ad_out", 16'(ad_out), 16'(addr[7:0]));
                end else if (h <= 8) begin
                    chk(wr ? "R4 ad_oe" : "R3 ad_oe", 16'(ad_oe), 16'(wr));
                    if (wr) chk("R4 ad_out", 16'(ad_out), 16'(wd));
                end else begin
                    chk("R10 ad_oe", 16'(ad_oe), 16'd0);
                end
                if (h <= 7) chk("R5 a_hi", 16'(a_hi), 16'(addr[15:8]));
                chk("R9 done", 16'(done), 16'(h == 8));
                if (h == 8 && !wr) chk({rtag, " rdata"}, 16'(rdata), 16'(mem_val));
            end
            if (poke) begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    chk("R9 ignored req ale", 16'(ale), 16'd0);
                    chk("R9 ignored req done", 16'(done), 16'd0);
                end
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset pins", {12'd0, ale, rd_n, wr_n, ad_oe}, 16'b0110);
        chk("R1 reset done", 16'(done), 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {11'd0, done, ale, rd_n, wr_n, ad_oe}, 16'b00110);

        access(2'd0, 16'h0040, 8'h00, 1'b1, 1'b0);  // R6 start-up fetch, internal
        access(2'd0, 16'h3FFF, 8'h00, 1'b1, 1'b0);  // R6 top of internal window
        access(2'd0, 16'h4000, 8'h00, 1'b1, 1'b0);  // R7 just above window
        access(2'd0, 16'h0040, 8'h00, 1'b0, 1'b0);  // R7 strap low
        access(2'd1, 16'h0123, 8'h00, 1'b1, 1'b0);  // R8 read below window
        access(2'd2, 16'h2345, 8'hC3, 1'b1, 1'b0);  // R8 write below window
        access(2'd3, 16'hFFFF, 8'h00, 1'b0, 1'b0);  // R3 kind 3 as read
        access(2'd1, 16'hA55A, 8'h00, 1'b0, 1'b1);  // R9 request while busy
        access(2'd2, 16'h00FF, 8'h7E, 1'b0, 1'b1);  // R9 during write

        for (int n = 0; n < 60; n++) begin
            access(2'($urandom), 16'($urandom), 8'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule